// File: doc/BRIEF.md
# SDRAM Write Burst Receiver

This block sits on the device side of a single data rate SDRAM command bus and turns write traffic into a plain memory write port. Each clock it decodes the strobe lines into a command, keeps a programmed burst length, walks the column address of a running write burst and, for every data word that belongs to a burst, presents the bank, row, column, data and byte enables on a registered write port. A small per-bank tracker records which banks hold an open row and which row that is.

Bursts of 1, 2, 4 or 8 words use sequential ordering inside an aligned block of the burst length. Full-page bursts step through every column, wrap to column 0 and run until another command cuts them off. A running burst can be ended early by a new WRITE, a READ, a BURST TERMINATE or a PRECHARGE that hits its bank. Address bit 10 on a WRITE requests an automatic close of the bank once the burst finishes. The column width is a parameter, so a reduced column space can stand in for a full page.

Top module: `sdr_wr_capture`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `wr_en` is 0 and every `bank_open` bit is 0; the burst length after reset is one word.
- R2: A command is taken only when `cke` is 1 and `cs_n` is 0; the strobes `{ras_n,cas_n,we_n}` then mean ACTIVATE 011, READ 101, WRITE 100, BURST TERMINATE 110, PRECHARGE 010, MODE LOAD 000; any other cycle is a no-operation.
- R3: The word on `dq` in the WRITE cycle is the first word of the burst, stored at bank `ba` and column `addr[COL_W-1:0]`; the write port shows it one clock later with `wr_row` equal to the row last activated in that bank.
- R4: MODE LOAD takes `addr[2:0]` as burst length code: 000 one word, 001 two, 010 four, 011 eight, 111 full page, any other code one word; fixed bursts step the column upward inside the aligned block of their length and wrap within it.
- R5: When a fixed-length burst has delivered all its words and no new command arrives, later `dq` input produces no write.
- R6: A full-page burst goes from the highest column to column 0 and keeps writing until a terminating command.
- R7: A WRITE during a running burst ends the old burst in that cycle; the word of that cycle is the first word of the new burst.
- R8: A READ during a write burst ends it; no word is written from the READ cycle on.
- R9: BURST TERMINATE ends a running burst and the word present in its cycle is not written.
- R10: PRECHARGE with `addr[10]`=0 closes bank `ba`, with `addr[10]`=1 closes all banks; if it hits the bank of the running burst, that burst ends and the word of that cycle is not written, otherwise the burst goes on.
- R11: A WRITE with `addr[10]`=1 on a fixed-length burst closes its bank on the clock edge that captures the last word, so `bank_open` drops in the same cycle the write port shows that word.
- R12: `wr_be[i]` is the inverse of `dqm[i]` on the capture edge, each bit covering one byte lane; a word with every lane masked gives no `wr_en` but still uses its burst slot.
- R13: ACTIVATE sets the `bank_open` bit of bank `ba` in the next cycle and records `addr` as that bank's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low turns the cycle into a no-operation |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Row, column, mode code and bit 10 close/all flag |
| dq | input | DQ_W | Write data |
| dqm | input | DQ_W/8 | Byte lane masks, 1 masks the lane |
| wr_en | output | 1 | Write port strobe |
| wr_bank | output | BA_W | Write bank |
| wr_row | output | ADDR_W | Write row |
| wr_col | output | COL_W | Write column |
| wr_data | output | DQ_W | Write data word |
| wr_be | output | DQ_W/8 | Write byte enables |
| bank_open | output | 2**BA_W | One bit per bank, 1 while a row is open |

## Verification
Every word that enters on a capture edge appears on the write port exactly one clock later, and bank open changes from ACTIVATE, PRECHARGE or the automatic close become visible one clock after the deciding edge. The bench drives each command on a falling edge and checks the outputs on the next falling edge, so each check sees the result of precisely the command it drove. Burst addresses are predicted from the programmed length and start column by a bench function, and the cycles after a burst ends or is cut are checked for the absence of a write before the next command is driven.

// File: rtl/sdr_wr_pkg.sv
package sdr_wr_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_OPEN,
        OP_READ,
        OP_WRITE,
        OP_STOP,
        OP_CLOSE,
        OP_RFSH,
        OP_MODE
    } op_e;

    typedef struct packed {
        op_e  op;
        logic a10;
    } cmd_t;

    localparam logic [2:0] LEN_FULL = 3'b111;

    function automatic op_e decode_op(input logic cke, input logic cs_n,
                                      input logic ras_n, input logic cas_n,
                                      input logic we_n);
        op_e o;
        o = OP_IDLE;
        if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  o = OP_OPEN;
                3'b101:  o = OP_READ;
                3'b100:  o = OP_WRITE;
                3'b110:  o = OP_STOP;
                3'b010:  o = OP_CLOSE;
                3'b001:  o = OP_RFSH;
                3'b000:  o = OP_MODE;
                default: o = OP_IDLE;
            endcase
        end
        return o;
    endfunction

    function automatic logic [2:0] len_mask(input logic [2:0] code);
        logic [2:0] m;
        case (code)
            3'b001:  m = 3'd1;
            3'b010:  m = 3'd3;
            3'b011:  m = 3'd7;
            default: m = 3'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sdr_cmd_dec.sv
module sdr_cmd_dec
    import sdr_wr_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_t cmd
);
    always_comb begin
        cmd.op  = decode_op(cke, cs_n, ras_n, cas_n, we_n);
        cmd.a10 = a10;
    end
endmodule

// File: rtl/sdr_burst_ctl.sv
module sdr_burst_ctl
    import sdr_wr_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  logic [BA_W-1:0]  ba,
    input  logic [COL_W-1:0] col,
    input  logic [2:0]       len_code,
    output logic             cap,
    output logic [BA_W-1:0]  cap_bank,
    output logic [COL_W-1:0] cap_col,
    output logic             ac_en,
    output logic [BA_W-1:0]  ac_bank
);
    localparam int LEFT_W = 3;

    function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                  input logic [COL_W-1:0] m);
        return (c & ~m) | ((c + COL_W'(1)) & m);
    endfunction

    logic [2:0]        mode_q;
    logic              run_q, full_q, ac_q;
    logic [BA_W-1:0]   bank_q;
    logic [COL_W-1:0]  col_q, mask_q;
    logic [LEFT_W-1:0] left_q;

    logic is_wr, is_rd, is_stop, is_close, close_hit, cont, new_full, single, last;
    logic [COL_W-1:0] new_mask;

    always_comb begin
        is_wr     = (cmd.op == OP_WRITE);
        is_rd     = (cmd.op == OP_READ);
        is_stop   = (cmd.op == OP_STOP);
        is_close  = (cmd.op == OP_CLOSE);
        close_hit = is_close && (cmd.a10 || (ba == bank_q));
        cont      = run_q && !is_wr && !is_rd && !is_stop && !close_hit;
        new_full  = (mode_q == LEN_FULL);
        new_mask  = new_full ? '1 : COL_W'(len_mask(mode_q));
        single    = !new_full && (new_mask == '0);
        last      = cont && !full_q && (left_q == LEFT_W'(1));
        cap       = is_wr || cont;
        cap_bank  = is_wr ? ba  : bank_q;
        cap_col   = is_wr ? col : col_q;
        ac_en     = (is_wr && single && cmd.a10) || (last && ac_q);
        ac_bank   = is_wr ? ba : bank_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 3'b000;
            run_q  <= 1'b0;
            full_q <= 1'b0;
            ac_q   <= 1'b0;
            bank_q <= '0;
            col_q  <= '0;
            mask_q <= '0;
            left_q <= '0;
        end else begin
            if (cmd.op == OP_MODE) begin
                mode_q <= len_code;
            end
            if (is_wr) begin
                run_q  <= !single;
                full_q <= new_full;
                ac_q   <= cmd.a10 && !new_full;
                bank_q <= ba;
                col_q  <= step_col(col, new_mask);
                mask_q <= new_mask;
                left_q <= new_mask[LEFT_W-1:0];
            end else if (cont) begin
                col_q <= step_col(col_q, mask_q);
                if (!full_q) begin
                    left_q <= left_q - LEFT_W'(1);
                    if (left_q == LEFT_W'(1)) begin
                        run_q <= 1'b0;
                    end
                end
            end else begin
                run_q <= 1'b0;
            end
        end
    end

    // R5: a fixed burst that used its last slot is idle afterwards
    a_r5_fixed_stops: assert property (@(posedge clk) disable iff (rst)
        (cont && !full_q && left_q == LEFT_W'(1) && !is_wr) |=> !run_q);

    // R6: a full-page burst that keeps going stays active
    a_r6_full_persists: assert property (@(posedge clk) disable iff (rst)
        (cont && full_q) |=> run_q);

    // R4: remaining count never exceeds the burst span
    a_r4_left_bound: assert property (@(posedge clk) disable iff (rst)
        (run_q && !full_q) |-> (left_q <= mask_q[LEFT_W-1:0]));
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track #(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13,
    localparam int NB   = 1 << BA_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       act_en,
    input  logic [BA_W-1:0]            act_bank,
    input  logic [ROW_W-1:0]           act_row,
    input  logic [NB-1:0]              close_vec,
    output logic [NB-1:0]              open_vec,
    output logic [NB-1:0][ROW_W-1:0]   row_of
);
    for (genvar i = 0; i < NB; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_vec[i] <= 1'b0;
                row_of[i]   <= '0;
            end else if (act_en && act_bank == BA_W'(i)) begin
                open_vec[i] <= 1'b1;
                row_of[i]   <= act_row;
            end else if (close_vec[i]) begin
                open_vec[i] <= 1'b0;
            end
        end
    end

    // R13: activation marks the bank open on the next cycle
    a_r13_act_opens: assert property (@(posedge clk) disable iff (rst)
        act_en |=> open_vec[$past(act_bank)]);
endmodule

// File: rtl/sdr_wr_capture.sv
module sdr_wr_capture
    import sdr_wr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int COL_W  = 4,
    parameter int DQ_W   = 16,
    localparam int NB    = 1 << BA_W,
    localparam int DM_W  = DQ_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq,
    input  logic [DM_W-1:0]   dqm,
    output logic              wr_en,
    output logic [BA_W-1:0]   wr_bank,
    output logic [ADDR_W-1:0] wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [DQ_W-1:0]   wr_data,
    output logic [DM_W-1:0]   wr_be,
    output logic [NB-1:0]     bank_open
);
    localparam int FLAG_BIT = 10;

    cmd_t                      cmd;
    logic                      cap, ac_en;
    logic [BA_W-1:0]           cap_bank, ac_bank;
    logic [COL_W-1:0]          cap_col;
    logic [NB-1:0]             close_vec;
    logic [NB-1:0][ADDR_W-1:0] row_of;

    sdr_cmd_dec i_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (addr[FLAG_BIT]),
        .cmd   (cmd)
    );

    sdr_burst_ctl #(.BA_W(BA_W), .COL_W(COL_W)) i_burst (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ba       (ba),
        .col      (addr[COL_W-1:0]),
        .len_code (addr[2:0]),
        .cap      (cap),
        .cap_bank (cap_bank),
        .cap_col  (cap_col),
        .ac_en    (ac_en),
        .ac_bank  (ac_bank)
    );

    always_comb begin
        close_vec = '0;
        if (cmd.op == OP_CLOSE) begin
            if (cmd.a10) close_vec = '1;
            else         close_vec[ba] = 1'b1;
        end
        if (ac_en) begin
            close_vec[ac_bank] = 1'b1;
        end
    end

    sdr_bank_track #(.BA_W(BA_W), .ROW_W(ADDR_W)) i_banks (
        .clk       (clk),
        .rst       (rst),
        .act_en    (cmd.op == OP_OPEN),
        .act_bank  (ba),
        .act_row   (addr),
        .close_vec (close_vec),
        .open_vec  (bank_open),
        .row_of    (row_of)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_bank <= '0;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_data <= '0;
            wr_be   <= '0;
        end else begin
            wr_en   <= cap && (dqm != '1);
            wr_bank <= cap_bank;
            wr_row  <= row_of[cap_bank];
            wr_col  <= cap_col;
            wr_data <= dq;
            wr_be   <= ~dqm;
        end
    end

    // R8: a READ cycle never yields a write
    a_r8_read_blocks: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_READ) |=> !wr_en);

    // R9: the terminate cycle word is dropped
    a_r9_stop_drops: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_STOP) |=> !wr_en);

    // R12: a fully masked word is not written
    a_r12_all_masked: assert property (@(posedge clk) disable iff (rst)
        (dqm == '1) |=> !wr_en);

    // R10: close-all leaves every bank closed
    a_r10_close_all: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_CLOSE && cmd.a10) |=> (bank_open == '0));

    // R2: a deselected cycle opens no bank
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !cke) |=> $stable(bank_open) || (bank_open == '0) ||
                           ($countones(bank_open) < $countones($past(bank_open))));
endmodule

// File: tb/test_sdr_wr_capture.sv
`timescale 1ns/1ps
module test_sdr_wr_capture;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int COL_W  = 4;
    localparam int DQ_W   = 16;
    localparam int NB     = 4;
    localparam int DM_W   = 2;
    localparam int NCOL   = 16;

    logic clk = 1'b0;
    logic rst, cke, cs_n, ras_n, cas_n, we_n;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic [DQ_W-1:0]   dq;
    logic [DM_W-1:0]   dqm;
    logic              wr_en;
    logic [BA_W-1:0]   wr_bank;
    logic [ADDR_W-1:0] wr_row;
    logic [COL_W-1:0]  wr_col;
    logic [DQ_W-1:0]   wr_data;
    logic [DM_W-1:0]   wr_be;
    logic [NB-1:0]     bank_open;

    int nchk = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    sdr_wr_capture #(.ADDR_W(ADDR_W), .BA_W(BA_W), .COL_W(COL_W), .DQ_W(DQ_W)) i_sdr_wr_capture (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .dq(dq), .dqm(dqm), .wr_en(wr_en),
        .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .wr_be(wr_be), .bank_open(bank_open)
    );

    function automatic int len_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return NCOL;
            default: return 1;
        endcase
    endfunction

    function automatic int col_at(input int start, input int code, input int k);
        int n;
        n = len_of(code);
        return (start & ~(n - 1)) | ((start + k) & (n - 1));
    endfunction

    task automatic drive(input logic k, input logic c, input logic r, input logic ca,
                         input logic w, input int b, input int a,
                         input logic [DQ_W-1:0] d, input logic [DM_W-1:0] m);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w;
        ba = BA_W'(b); addr = ADDR_W'(a); dq = d; dqm = m;
        @(negedge clk);
    endtask

    task automatic t_nop(input logic [DQ_W-1:0] d, input logic [DM_W-1:0] m);
        drive(1, 0, 1, 1, 1, 0, 0, d, m);
    endtask
    task automatic t_wr(input int b, input int c, input int ap,
                        input logic [DQ_W-1:0] d, input logic [DM_W-1:0] m);
        drive(1, 0, 1, 0, 0, b, c | (ap << 10), d, m);
    endtask
    task automatic t_act(input int b, input int row);
        drive(1, 0, 0, 1, 1, b, row, 16'h0bad, 2'b00);
    endtask
    task automatic t_rd(input int b, input int c, input logic [DQ_W-1:0] d);
        drive(1, 0, 1, 0, 1, b, c, d, 2'b00);
    endtask
    task automatic t_stop(input logic [DQ_W-1:0] d);
        drive(1, 0, 1, 1, 0, 0, 0, d, 2'b00);
    endtask
    task automatic t_pre(input int b, input int all, input logic [DQ_W-1:0] d);
        drive(1, 0, 0, 1, 0, b, all << 10, d, 2'b00);
    endtask
    task automatic t_mode(input int code);
        drive(1, 0, 0, 0, 0, 0, code, 16'h0, 2'b00);
    endtask

    task automatic chk_w(input string req, input bit en, input int b, input int c,
                         input logic [DQ_W-1:0] d, input logic [DM_W-1:0] be);
        nchk++;
        if (!en) begin
            if (wr_en !== 1'b0) begin
                nbad++;
                $display("FAIL %s: wr_en=%b expected 0", req, wr_en);
            end
        end else if (wr_en !== 1'b1 || wr_bank !== BA_W'(b) || wr_col !== COL_W'(c) ||
                     wr_data !== d || wr_be !== be) begin
            nbad++;
            $display("FAIL %s: en=%b bank=%0d col=%0d data=%h be=%b expected en=1 bank=%0d col=%0d data=%h be=%b",
                     req, wr_en, wr_bank, wr_col, wr_data, wr_be, b, c, d, be);
        end
    endtask

    task automatic chk_open(input string req, input logic [NB-1:0] e);
        nchk++;
        if (bank_open !== e) begin
            nbad++;
            $display("FAIL %s: bank_open=%b expected %b", req, bank_open, e);
        end
    endtask

    task automatic chk_row(input string req, input int e);
        nchk++;
        if (wr_row !== ADDR_W'(e)) begin
            nbad++;
            $display("FAIL %s: wr_row=%h expected %h", req, wr_row, ADDR_W'(e));
        end
    endtask

    initial begin
        #(4 * 100000);
        nbad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        ba = '0; addr = '0; dq = '0; dqm = '0;
        repeat (3) @(negedge clk);
        chk_w("R1 reset write", 0, 0, 0, 0, 0);
        chk_open("R1 reset banks", 4'b0000);
        rst = 1'b0;
        t_nop(16'h1111, 2'b00);
        chk_w("R1 first cycle", 0, 0, 0, 0, 0);

        // R13 activation
        t_act(1, 13'h055);
        chk_open("R13 open bank1", 4'b0010);

        // R3 single word at reset length
        t_wr(1, 3, 0, 16'hA0A0, 2'b00);
        chk_w("R3 first word", 1, 1, 3, 16'hA0A0, 2'b11);
        chk_row("R3 row", 13'h055);
        t_nop(16'hDEAD, 2'b00);
        chk_w("R5 after single", 0, 0, 0, 0, 0);

        // R2 deselect and clock disable
        drive(1, 1, 1, 0, 0, 1, 5, 16'h2222, 2'b00);
        chk_w("R2 cs high", 0, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 1, 5, 16'h3333, 2'b00);
        chk_w("R2 cke low", 0, 0, 0, 0, 0);

        // R4 length four wraps in block
        t_mode(2);
        t_wr(1, 6, 0, 16'h4000, 2'b00);
        chk_w("R4 bl4 w0", 1, 1, 6, 16'h4000, 2'b11);
        for (int k = 1; k < 4; k++) begin
            t_nop(16'h4000 + 16'(k), 2'b00);
            chk_w("R4 bl4", 1, 1, col_at(6, 2, k), 16'h4000 + 16'(k), 2'b11);
        end
        t_nop(16'hBEEF, 2'b00);
        chk_w("R5 after bl4", 0, 0, 0, 0, 0);

        // R4 length eight
        t_mode(3);
        t_wr(1, 5, 0, 16'h8000, 2'b00);
        chk_w("R4 bl8 w0", 1, 1, 5, 16'h8000, 2'b11);
        for (int k = 1; k < 8; k++) begin
            t_nop(16'h8000 + 16'(k), 2'b00);
            chk_w("R4 bl8", 1, 1, col_at(5, 3, k), 16'h8000 + 16'(k), 2'b11);
        end
        t_nop(16'hBEEF, 2'b00);
        chk_w("R5 after bl8", 0, 0, 0, 0, 0);

        // R6 full page wraps, R9 terminate drops
        t_mode(7);
        t_wr(1, 14, 0, 16'hF000, 2'b00);
        chk_w("R6 full w0", 1, 1, 14, 16'hF000, 2'b11);
        for (int k = 1; k < 20; k++) begin
            t_nop(16'hF000 + 16'(k), 2'b00);
            chk_w("R6 full wrap", 1, 1, (14 + k) % NCOL, 16'hF000 + 16'(k), 2'b11);
        end
        t_stop(16'h5555);
        chk_w("R9 stop word", 0, 0, 0, 0, 0);
        t_nop(16'h6666, 2'b00);
        chk_w("R9 after stop", 0, 0, 0, 0, 0);

        // R7 write cuts write
        t_mode(2);
        t_wr(1, 0, 0, 16'h7000, 2'b00);
        chk_w("R7 old w0", 1, 1, 0, 16'h7000, 2'b11);
        t_wr(2, 8, 0, 16'h7100, 2'b00);
        chk_w("R7 new w0", 1, 2, 8, 16'h7100, 2'b11);
        for (int k = 1; k < 4; k++) begin
            t_nop(16'h7100 + 16'(k), 2'b00);
            chk_w("R7 new burst", 1, 2, 8 + k, 16'h7100 + 16'(k), 2'b11);
        end
        t_nop(16'h0, 2'b00);
        chk_w("R7 end", 0, 0, 0, 0, 0);

        // R8 read cuts write
        t_wr(1, 4, 0, 16'h8800, 2'b00);
        chk_w("R8 w0", 1, 1, 4, 16'h8800, 2'b11);
        t_rd(1, 0, 16'h8801);
        chk_w("R8 read cycle", 0, 0, 0, 0, 0);
        t_nop(16'h8802, 2'b00);
        chk_w("R8 after read", 0, 0, 0, 0, 0);

        // R10 precharge other bank, then own bank
        t_act(0, 13'h011);
        chk_open("R13 open bank0", 4'b0011);
        t_mode(3);
        t_wr(1, 0, 0, 16'hA100, 2'b00);
        chk_w("R10 w0", 1, 1, 0, 16'hA100, 2'b11);
        t_nop(16'hA101, 2'b00);
        chk_w("R10 w1", 1, 1, 1, 16'hA101, 2'b11);
        t_pre(0, 0, 16'hA102);
        chk_w("R10 other bank keeps burst", 1, 1, 2, 16'hA102, 2'b11);
        chk_open("R10 bank0 closed", 4'b0010);
        t_pre(1, 0, 16'hA103);
        chk_w("R10 own bank drops word", 0, 0, 0, 0, 0);
        chk_open("R10 bank1 closed", 4'b0000);
        t_nop(16'hA104, 2'b00);
        chk_w("R10 burst ended", 0, 0, 0, 0, 0);

        // R11 auto close at burst end
        t_act(3, 13'h007);
        t_mode(1);
        t_wr(3, 4, 1, 16'hC000, 2'b00);
        chk_w("R11 w0", 1, 3, 4, 16'hC000, 2'b11);
        chk_open("R11 open during burst", 4'b1000);
        t_nop(16'hC001, 2'b00);
        chk_w("R11 last word", 1, 3, 5, 16'hC001, 2'b11);
        chk_open("R11 closed at end", 4'b0000);

        // R12 byte masks
        t_mode(0);
        t_wr(1, 2, 0, 16'hD00D, 2'b01);
        chk_w("R12 lane mask", 1, 1, 2, 16'hD00D, 2'b10);
        t_wr(1, 3, 0, 16'hD00E, 2'b11);
        chk_w("R12 all masked", 0, 0, 0, 0, 0);

        // R10 close all
        t_act(0, 1);
        t_act(2, 2);
        chk_open("R13 two banks", 4'b0101);
        t_pre(0, 1, 16'h0);
        chk_open("R10 close all", 4'b0000);

        // random bursts, R4 R5 R6 R12
        for (int n = 0; n < 40; n++) begin
            int code, b, st, len;
            logic [DQ_W-1:0] d;
            logic [DM_W-1:0] m;
            case ($urandom_range(0, 4))
                0: code = 0;
                1: code = 1;
                2: code = 2;
                3: code = 3;
                default: code = 7;
            endcase
            t_mode(code);
            chk_w("R5 idle at mode load", 0, 0, 0, 0, 0);
            b   = $urandom_range(0, 3);
            st  = $urandom_range(0, NCOL - 1);
            len = (code == 7) ? $urandom_range(3, 20) : len_of(code);
            d = DQ_W'($urandom);
            m = DM_W'($urandom_range(0, 3));
            t_wr(b, st, 0, d, m);
            chk_w("R3 R12 random first", m != 2'b11, b, st, d, ~m);
            for (int k = 1; k < len; k++) begin
                d = DQ_W'($urandom);
                m = DM_W'($urandom_range(0, 3));
                t_nop(d, m);
                chk_w("R4 R6 random burst", m != 2'b11, b,
                      (code == 7) ? (st + k) % NCOL : col_at(st, code, k), d, ~m);
            end
            if (code == 7) begin
                t_stop(16'h1234);
                chk_w("R9 random stop", 0, 0, 0, 0, 0);
            end else begin
                t_nop(16'h1234, 2'b00);
                chk_w("R5 random end", 0, 0, 0, 0, 0);
            end
        end

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule